// File: doc/BRIEF.md
# USB Line Symbol NRZI Decoder with Bit Destuffing

This block sits behind a line sampler that has already recovered bit timing on a low- or full-speed USB pair. Each bit time the sampler presents one classified line symbol (J, K, SE0 or SE1) with a valid strobe. The block turns that symbol stream into packet-level bit events.

While the line is idle, the block waits for the first K, which marks the start of a packet. It then converts each data symbol to a bit by NRZI rules. It drops the zero that the transmitter inserts after a run of ones, and it flags that zero as a stuff bit. A run of ones that is too long is a stuff violation. An SE0 starts the end-of-packet check. That check must finish with J; any other symbol is an end-of-packet error. Both errors return the block to idle.

Every event appears as a one-cycle strobe, registered one clock after the symbol that caused it. Each accepted symbol produces at most one strobe. The run length that forces a stuff bit is a parameter (`STUFF_LEN`, default six).

Top module: `usb_nrzi_rx`

## Requirements
- R1: Symbol coding on `sym_i` is J=0, K=1, SE0=2, SE1=3. While `rst_ni` is low and after it is released, every output is 0, the block is idle, the previous symbol is J and the ones counter is zero.
- R2: In idle, a valid K pulses `sop_o` in the next cycle and enters bit-receive. A valid J, SE0 or SE1 in idle produces no event, and the block stays idle.
- R3: In bit-receive, a symbol that equals the previous accepted symbol decodes to 1, and one that differs decodes to 0. An ordinary data bit is reported by `bit_valid_o` with its value on `bit_o`.
- R4: An ordinary data 1 increments the ones counter and a data 0 clears it. Start of packet also clears the counter, so a run left over from an earlier packet never counts.
- R5: When the counter holds `STUFF_LEN` ones, a following 0 pulses `stuff_o` instead of `bit_valid_o` and clears the counter.
- R6: When the counter holds `STUFF_LEN` ones, a following 1 pulses `stuff_err_o` and returns the block to idle.
- R7: An SE0 in bit-receive produces no event and enters the end-of-packet state.
- R8: In the end-of-packet state, further SE0 symbols produce no event. A J pulses `eop_o` and returns the block to idle.
- R9: In the end-of-packet state, a K or SE1 pulses `eop_err_o` and returns the block to idle.
- R10: A cycle with `sym_valid_i` low changes no state, leaves the previous symbol untouched and produces no event in the following cycle.
- R11: Each event output is registered one cycle after its symbol, and at most one event output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_valid_i | input | 1 | Line symbol strobe, one per bit time |
| sym_i | input | 2 | Line symbol: J=0, K=1, SE0=2, SE1=3 |
| sop_o | output | 1 | Start-of-packet strobe |
| bit_valid_o | output | 1 | Data bit strobe |
| bit_o | output | 1 | Decoded data bit value, valid with `bit_valid_o` |
| stuff_o | output | 1 | Stuff bit removed |
| eop_o | output | 1 | End of packet completed |
| stuff_err_o | output | 1 | Run of ones exceeded the stuff length |
| eop_err_o | output | 1 | End-of-packet sequence broken by K or SE1 |

## Verification
The in-RTL properties check every cycle that the state machine steps correctly. They cover SOP entry from idle, the move to the end-of-packet state on SE0, the J and error exits, and the return to idle after a stuff violation. They also check that the counter stays within its bound, that the previous symbol tracks the accepted symbols, that invalid cycles stay quiet, and that the event strobes are mutually exclusive. Only the bench's symbol sequences can show that the bit values are right across packets. Those sequences also show that the counter resets at SOP and at a data zero, which moves where a stuff bit or violation lands. A reset in mid-packet, and stalls inside a packet that leave the NRZI reference unchanged, are likewise shown only by the bench.

// File: rtl/usb_nrzi_pkg.sv
package usb_nrzi_pkg;

  typedef enum logic [1:0] {
    SYM_J   = 2'd0,
    SYM_K   = 2'd1,
    SYM_SE0 = 2'd2,
    SYM_SE1 = 2'd3
  } line_sym_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BIT  = 2'd1,
    ST_EOP  = 2'd2
  } rx_state_e;

endpackage

// File: rtl/usb_nrzi_dec.sv
module usb_nrzi_dec
  import usb_nrzi_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sym_valid_i,
  input  line_sym_e sym_i,
  output logic      bit_o
);

  line_sym_e prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          prev_q <= SYM_J;
    else if (sym_valid_i) prev_q <= sym_i;
  end

  // NRZI: no transition means 1
  assign bit_o = (sym_i == prev_q);

  assert_prev_tracks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_i |=> prev_q == $past(sym_i));

  assert_prev_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_valid_i |=> $stable(prev_q));

endmodule

// File: rtl/usb_destuff.sv
module usb_destuff #(
  parameter int STUFF_LEN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  input  logic bit_i,
  output logic stuff_o,
  output logic viol_o
);

  localparam int CNT_W = $clog2(STUFF_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STUFF_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic             at_lim;

  assign at_lim  = (cnt_q == CNT_MAX);
  assign stuff_o = at_lim && !bit_i;
  assign viol_o  = at_lim && bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (step_i) begin
      if (at_lim || !bit_i)     cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);

  assert_clr_sop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);

  assert_zero_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && !bit_i) |=> cnt_q == '0);

  assert_one_counts_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && bit_i && !at_lim) |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/usb_nrzi_rx.sv
module usb_nrzi_rx
  import usb_nrzi_pkg::*;
#(
  parameter int STUFF_LEN = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sym_valid_i,
  input  logic [1:0] sym_i,
  output logic       sop_o,
  output logic       bit_valid_o,
  output logic       bit_o,
  output logic       stuff_o,
  output logic       eop_o,
  output logic       stuff_err_o,
  output logic       eop_err_o
);

  line_sym_e sym;
  rx_state_e state_q, state_d;
  logic      nrzi_bit, is_stuff, is_viol;
  logic      cnt_clr, cnt_step;
  logic      sop_d, bv_d, bit_d, stuff_d, eop_d, serr_d, eerr_d;
  logic [5:0] ev_all;

  assign sym = line_sym_e'(sym_i);

  usb_nrzi_dec u_nrzi (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sym_valid_i (sym_valid_i),
    .sym_i       (sym),
    .bit_o       (nrzi_bit)
  );

  usb_destuff #(.STUFF_LEN(STUFF_LEN)) u_destuff (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cnt_clr),
    .step_i  (cnt_step),
    .bit_i   (nrzi_bit),
    .stuff_o (is_stuff),
    .viol_o  (is_viol)
  );

  always_comb begin
    state_d  = state_q;
    cnt_clr  = 1'b0;
    cnt_step = 1'b0;
    sop_d    = 1'b0;
    bv_d     = 1'b0;
    bit_d    = 1'b0;
    stuff_d  = 1'b0;
    eop_d    = 1'b0;
    serr_d   = 1'b0;
    eerr_d   = 1'b0;
    if (sym_valid_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (sym == SYM_K) begin
            sop_d   = 1'b1;
            cnt_clr = 1'b1;
            state_d = ST_BIT;
          end
        end
        ST_BIT: begin
          if (sym == SYM_SE0) begin
            state_d = ST_EOP;
          end else begin
            cnt_step = 1'b1;
            if (is_stuff) begin
              stuff_d = 1'b1;
            end else if (is_viol) begin
              serr_d  = 1'b1;
              state_d = ST_IDLE;
            end else begin
              bv_d  = 1'b1;
              bit_d = nrzi_bit;
            end
          end
        end
        ST_EOP: begin
          if (sym == SYM_J) begin
            eop_d   = 1'b1;
            state_d = ST_IDLE;
          end else if (sym != SYM_SE0) begin
            eerr_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sop_o       <= 1'b0;
      bit_valid_o <= 1'b0;
      bit_o       <= 1'b0;
      stuff_o     <= 1'b0;
      eop_o       <= 1'b0;
      stuff_err_o <= 1'b0;
      eop_err_o   <= 1'b0;
    end else begin
      state_q     <= state_d;
      sop_o       <= sop_d;
      bit_valid_o <= bv_d;
      bit_o       <= bit_d;
      stuff_o     <= stuff_d;
      eop_o       <= eop_d;
      stuff_err_o <= serr_d;
      eop_err_o   <= eerr_d;
    end
  end

  assign ev_all = {sop_o, bit_valid_o, stuff_o, eop_o, stuff_err_o, eop_err_o};

  assert_one_event_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ev_all) <= 1);

  assert_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_valid_i |=> ev_all == '0);

  assert_sop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && sym_valid_i && sym == SYM_K) |=> (sop_o && state_q == ST_BIT));

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && sym_valid_i && sym != SYM_K) |=> (state_q == ST_IDLE && ev_all == '0));

  assert_serr_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuff_err_o |-> state_q == ST_IDLE);

  assert_se0_enter_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BIT && sym_valid_i && sym == SYM_SE0) |=> (state_q == ST_EOP && ev_all == '0));

  assert_eop_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EOP && sym_valid_i && sym == SYM_J) |=> (eop_o && state_q == ST_IDLE));

  assert_eop_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EOP && sym_valid_i && (sym == SYM_K || sym == SYM_SE1))
      |=> (eop_err_o && state_q == ST_IDLE));

endmodule

// File: tb/sim_usb_nrzi_rx.sv
module sim_usb_nrzi_rx;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  localparam logic [1:0] S_J = 2'd0, S_K = 2'd1, S_S0 = 2'd2, S_S1 = 2'd3;
  localparam logic [2:0] E_NO = 3'd0, E_SOP = 3'd1, E_B0 = 3'd2, E_B1 = 3'd3,
                         E_STF = 3'd4, E_EOP = 3'd5, E_SER = 3'd6, E_EER = 3'd7;

  // {req[3:0], symbol[1:0], expected event[2:0]}
  localparam int N_VEC = 64;
  localparam logic [8:0] VEC [N_VEC] = '{
    // packet with mixed bits, clean EOP: R2 R3 R7 R8
    {4'd2,S_J,E_NO}, {4'd2,S_K,E_SOP}, {4'd3,S_K,E_B1}, {4'd3,S_J,E_B0},
    {4'd3,S_J,E_B1}, {4'd3,S_K,E_B0}, {4'd7,S_S0,E_NO}, {4'd8,S_S0,E_NO},
    {4'd8,S_J,E_EOP},
    // six ones then stuffed zero: R5, count restarts R4
    {4'd2,S_K,E_SOP}, {4'd5,S_K,E_B1}, {4'd5,S_K,E_B1}, {4'd5,S_K,E_B1},
    {4'd5,S_K,E_B1}, {4'd5,S_K,E_B1}, {4'd5,S_K,E_B1}, {4'd5,S_J,E_STF},
    {4'd4,S_J,E_B1}, {4'd3,S_K,E_B0}, {4'd7,S_S0,E_NO}, {4'd8,S_J,E_EOP},
    // seven ones: stuff violation R6, idle ignores non-K R2
    {4'd2,S_K,E_SOP}, {4'd6,S_K,E_B1}, {4'd6,S_K,E_B1}, {4'd6,S_K,E_B1},
    {4'd6,S_K,E_B1}, {4'd6,S_K,E_B1}, {4'd6,S_K,E_B1}, {4'd6,S_K,E_SER},
    {4'd2,S_J,E_NO}, {4'd2,S_S0,E_NO}, {4'd2,S_S1,E_NO}, {4'd2,S_K,E_SOP},
    // five ones, SE0 then SE1: R9; new SOP clears count R4
    {4'd4,S_K,E_B1}, {4'd4,S_K,E_B1}, {4'd4,S_K,E_B1}, {4'd4,S_K,E_B1},
    {4'd4,S_K,E_B1}, {4'd7,S_S0,E_NO}, {4'd9,S_S1,E_EER}, {4'd4,S_K,E_SOP},
    {4'd4,S_K,E_B1}, {4'd4,S_K,E_B1}, {4'd4,S_K,E_B1}, {4'd4,S_K,E_B1},
    {4'd4,S_K,E_B1}, {4'd4,S_K,E_B1}, {4'd4,S_J,E_STF}, {4'd7,S_S0,E_NO},
    {4'd8,S_S0,E_NO}, {4'd9,S_K,E_EER},
    // data zero clears the run R4
    {4'd2,S_K,E_SOP}, {4'd4,S_K,E_B1}, {4'd4,S_K,E_B1}, {4'd4,S_J,E_B0},
    {4'd4,S_J,E_B1}, {4'd4,S_J,E_B1}, {4'd4,S_J,E_B1}, {4'd4,S_J,E_B1},
    {4'd4,S_J,E_B1}, {4'd4,S_J,E_B1}, {4'd5,S_K,E_STF}, {4'd7,S_S0,E_NO},
    {4'd8,S_J,E_EOP}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sym_valid_i = 1'b0;
  logic [1:0] sym_i = S_J;
  logic       sop_o, bit_valid_o, bit_o, stuff_o, eop_o, stuff_err_o, eop_err_o;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_nrzi_rx u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .sym_valid_i (sym_valid_i),
    .sym_i       (sym_i),
    .sop_o       (sop_o),
    .bit_valid_o (bit_valid_o),
    .bit_o       (bit_o),
    .stuff_o     (stuff_o),
    .eop_o       (eop_o),
    .stuff_err_o (stuff_err_o),
    .eop_err_o   (eop_err_o)
  );

  function automatic logic [2:0] ev_code();
    if (sop_o)       return E_SOP;
    if (bit_valid_o) return bit_o ? E_B1 : E_B0;
    if (stuff_o)     return E_STF;
    if (eop_o)       return E_EOP;
    if (stuff_err_o) return E_SER;
    if (eop_err_o)   return E_EER;
    return E_NO;
  endfunction

  task automatic check_ev(input logic [2:0] exp, input int req);
    int hi;
    hi = sop_o + bit_valid_o + stuff_o + eop_o + stuff_err_o + eop_err_o;
    n_checks++;
    if (hi > 1) begin
      n_errors++;
      $display("FAIL R11: %0d event outputs high, expected at most 1", hi);
    end else if (ev_code() !== exp) begin
      n_errors++;
      $display("FAIL R%0d: event %0d, expected %0d", req, ev_code(), exp);
    end
  endtask

  // drive at negedge, register at posedge, sample at next negedge
  task automatic send(input logic [1:0] s);
    sym_i = s;
    sym_valid_i = 1'b1;
    @(negedge clk);
    sym_valid_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_ev(E_NO, 1);  // R1: all outputs low in reset
    rst_ni = 1'b1;
    @(negedge clk);
    check_ev(E_NO, 1);  // R1: quiet after release

    for (int i = 0; i < N_VEC; i++) begin
      send(VEC[i][4:3]);
      check_ev(VEC[i][2:0], int'(VEC[i][8:5]));
    end

    // R10: stalls inside a packet keep the NRZI reference
    send(S_K);
    check_ev(E_SOP, 2);
    for (int c = 0; c < 3; c++) begin
      sym_i = (c == 1) ? S_S0 : S_J;
      @(negedge clk);
      check_ev(E_NO, 10);
    end
    send(S_K);
    check_ev(E_B1, 10);  // R10: reference still K
    send(S_J);
    check_ev(E_B0, 3);

    // R1: reset mid-packet returns to idle
    send(S_J);
    check_ev(E_B1, 3);
    sym_i = S_J;
    sym_valid_i = 1'b1;
    rst_ni = 1'b0;
    @(negedge clk);
    check_ev(E_NO, 1);
    sym_valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk);
    send(S_J);
    check_ev(E_NO, 1);   // R1: idle after reset, J ignored
    send(S_S0);
    check_ev(E_NO, 1);   // R1: idle, SE0 is not an EOP
    send(S_K);
    check_ev(E_SOP, 1);
    send(S_J);
    check_ev(E_B0, 3);
    send(S_S0);
    check_ev(E_NO, 7);
    send(S_J);
    check_ev(E_EOP, 8);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule